// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a circular queue of transmit descriptors that software keeps in system memory. Each descriptor takes two 32-bit words: first the address of a fragment buffer, then a control word. A parallel status array holds one 32-bit word per descriptor. Software programs both array bases, the ring size and a produce index through a small register port. Whenever the engine's consume index differs from the produce index, it fetches the descriptor at the consume slot. It then hands the fragment (address, length, last flag) to the framing logic over a valid/ready port, writes a status word back, and steps the consume index. The index wraps to zero after the last slot.

Two interrupt status bits record progress. The fragment-done bit (bit 0) is set when a finished descriptor asked for an interrupt. The ring-done bit (bit 1) is set when the consume index reaches the produce index. An enable mask decides which status bits drive the interrupt line. Software clears status bits by writing ones to a clear register.

The engine is one state machine. Its states are IDLE, FETCH_PTR, FETCH_CTL, ISSUE, WRITE_STAT and STEP, and it moves through them as follows:
- IDLE→FETCH_PTR when the consume index is not equal to the produce index.
- FETCH_PTR→FETCH_CTL when the pointer read is acknowledged.
- FETCH_CTL→ISSUE when the control read is acknowledged.
- ISSUE→WRITE_STAT when the fragment is accepted.
- WRITE_STAT→STEP when the status write is acknowledged.
- STEP→IDLE always.

Every other combination holds the current state.

Register map (word index on the 3-bit register address):

| Index | Register | Access |
|---|---|---|
| 0 | descriptor base | read/write |
| 1 | status base | read/write |
| 2 | ring last (count−1) | read/write |
| 3 | produce index | read/write |
| 4 | consume index | read only |
| 5 | interrupt enable | read/write |
| 6 | interrupt status | read only |
| 7 | interrupt clear | write one to clear, reads 0 |

Top module: `txr_dma_top`

## Requirements
- R1: After reset all eight registers read 0, `irq` is 0, and neither `mem_req` nor `frag_valid` is asserted.
- R2: For consume index i, the engine reads the pointer at descriptor base + 8·i and then the control word at descriptor base + 8·i + 4. Base bits [1:0] are forced to 0.
- R3: The fragment request carries the fetched pointer on `frag_addr`, control bits [10:0] (byte count minus one) on `frag_len`, and control bit 30 on `frag_last`. All of these stay stable while `frag_valid` is high and `frag_ready` is low.
- R4: The status word is written to status base + 4·i. It holds the length field in bits [10:0] and the last flag in bit 30, and all other bits are 0.
- R5: One cycle after the status write is acknowledged, the consume index (register 4) advances by one. After the value in register 2 it wraps to 0.
- R6: While the consume index equals the produce index, the engine issues no memory or fragment requests.
- R7: Completing a descriptor whose control bit 31 is set sets status bit 0. Status bit 1 is set only when the advanced consume index equals the produce index.
- R8: Writing 1s to register 7 clears the matching status bits. If the engine sets a bit in the same cycle that software clears it, the bit ends up set.
- R9: `irq` is the OR of status ANDed with enable. Writing the enable register never alters the status bits.
- R10: Writes to the consume index and status registers are ignored.
- R11: A memory request holds `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr_en | input | 1 | register write strobe |
| reg_wr_addr | input | 3 | register write index |
| reg_wr_data | input | 32 | register write data |
| reg_rd_addr | input | 3 | register read index |
| reg_rd_data | output | 32 | register read data (combinational) |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address |
| mem_wdata | output | 32 | write data (status word) |
| mem_ack | input | 1 | request accepted; read data valid this cycle |
| mem_rdata | input | 32 | read data |
| frag_valid | output | 1 | fragment request valid |
| frag_addr | output | 32 | fragment buffer address |
| frag_len | output | 11 | fragment byte count minus one |
| frag_last | output | 1 | last fragment of a frame |
| frag_ready | input | 1 | fragment request accepted |
| irq | output | 1 | masked interrupt |

## Verification
The engine setting a status bit in STEP and software writing the clear register can land on the same clock edge. The bench provokes this by waiting for the status write to be acknowledged and then holding a clear of both bits for exactly the next cycle, which is the STEP cycle. Beforehand the fragment-done bit is set and the descriptor carries no interrupt request. The judgement is that bit 0 reads back cleared while bit 1 reads back set.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 11;
    localparam int NUM_IRQ  = 2;
    localparam int BIT_IRQ  = 31;
    localparam int BIT_LAST = 30;

    localparam logic [2:0] RA_DBASE = 3'd0;
    localparam logic [2:0] RA_SBASE = 3'd1;
    localparam logic [2:0] RA_LAST  = 3'd2;
    localparam logic [2:0] RA_PROD  = 3'd3;
    localparam logic [2:0] RA_CONS  = 3'd4;
    localparam logic [2:0] RA_EN    = 3'd5;
    localparam logic [2:0] RA_STAT  = 3'd6;
    localparam logic [2:0] RA_CLR   = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_PTR, ST_FETCH_CTL, ST_ISSUE, ST_WRITE_STAT, ST_STEP
    } walk_state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [2:0]         rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic [WORD_W-1:0]  desc_base,
    output logic [WORD_W-1:0]  stat_base,
    output logic [IDX_W-1:0]   ring_last,
    output logic [IDX_W-1:0]   produce,
    input  logic [IDX_W-1:0]   consume,
    input  logic               set_frag,
    input  logic               set_ring,
    output logic               irq
);
    logic [WORD_W-3:0]  dbase_q, sbase_q;
    logic [IDX_W-1:0]   last_q, prod_q;
    logic [NUM_IRQ-1:0] en_q, stat_q, clr_mask, set_mask;

    assign clr_mask = (wr_en && wr_addr == RA_CLR) ? wr_data[NUM_IRQ-1:0] : '0;
    assign set_mask = {set_ring, set_frag};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbase_q <= '0;
            sbase_q <= '0;
            last_q  <= '0;
            prod_q  <= '0;
            en_q    <= '0;
            stat_q  <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    RA_DBASE: dbase_q <= wr_data[WORD_W-1:2];
                    RA_SBASE: sbase_q <= wr_data[WORD_W-1:2];
                    RA_LAST:  last_q  <= wr_data[IDX_W-1:0];
                    RA_PROD:  prod_q  <= wr_data[IDX_W-1:0];
                    RA_EN:    en_q    <= wr_data[NUM_IRQ-1:0];
                    default:  ;
                endcase
            end
            stat_q <= (stat_q & ~clr_mask) | set_mask;
        end
    end

    always_comb begin
        unique case (rd_addr)
            RA_DBASE: rd_data = {dbase_q, 2'b00};
            RA_SBASE: rd_data = {sbase_q, 2'b00};
            RA_LAST:  rd_data = WORD_W'(last_q);
            RA_PROD:  rd_data = WORD_W'(prod_q);
            RA_CONS:  rd_data = WORD_W'(consume);
            RA_EN:    rd_data = WORD_W'(en_q);
            RA_STAT:  rd_data = WORD_W'(stat_q);
            default:  rd_data = '0;
        endcase
    end

    assign desc_base = {dbase_q, 2'b00};
    assign stat_base = {sbase_q, 2'b00};
    assign ring_last = last_q;
    assign produce   = prod_q;
    assign irq       = |(stat_q & en_q);

    // R9: an enable write leaves status untouched
    a_r9_enable_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_EN && !set_frag && !set_ring) |=> $stable(stat_q));
    // R8: a set from the engine survives a concurrent clear
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_ring |=> stat_q[1]);
    a_r8_frag_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_frag |=> stat_q[0]);
endmodule

// File: rtl/txr_walker.sv
module txr_walker
    import txr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  desc_base,
    input  logic [WORD_W-1:0]  stat_base,
    input  logic [IDX_W-1:0]   ring_last,
    input  logic [IDX_W-1:0]   produce,
    output logic [IDX_W-1:0]   consume,
    output logic               set_frag,
    output logic               set_ring,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               frag_valid,
    output logic [WORD_W-1:0]  frag_addr,
    output logic [LEN_W-1:0]   frag_len,
    output logic               frag_last,
    input  logic               frag_ready
);
    localparam int PAD_D = WORD_W - IDX_W - 3;
    localparam int PAD_S = WORD_W - IDX_W - 2;

    walk_state_e        state_q, state_d;
    logic [IDX_W-1:0]   ci_q, ci_nxt;
    logic [WORD_W-1:0]  ptr_q, desc_addr, stat_addr;
    logic [LEN_W-1:0]   len_q;
    logic               irq_q, last_q;

    assign ci_nxt    = (ci_q == ring_last) ? '0 : ci_q + 1'b1;
    assign desc_addr = desc_base + {{PAD_D{1'b0}}, ci_q, 3'b000};
    assign stat_addr = stat_base + {{PAD_S{1'b0}}, ci_q, 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (ci_q != produce) state_d = ST_FETCH_PTR;
            ST_FETCH_PTR:  if (mem_ack)         state_d = ST_FETCH_CTL;
            ST_FETCH_CTL:  if (mem_ack)         state_d = ST_ISSUE;
            ST_ISSUE:      if (frag_ready)      state_d = ST_WRITE_STAT;
            ST_WRITE_STAT: if (mem_ack)         state_d = ST_STEP;
            ST_STEP:                            state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ci_q   <= '0;
            ptr_q  <= '0;
            len_q  <= '0;
            irq_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            if (state_q == ST_FETCH_PTR && mem_ack) ptr_q <= mem_rdata;
            if (state_q == ST_FETCH_CTL && mem_ack) begin
                irq_q  <= mem_rdata[BIT_IRQ];
                last_q <= mem_rdata[BIT_LAST];
                len_q  <= mem_rdata[LEN_W-1:0];
            end
            if (state_q == ST_STEP) ci_q <= ci_nxt;
        end
    end

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        frag_valid = 1'b0;
        set_frag   = 1'b0;
        set_ring   = 1'b0;
        unique case (state_q)
            ST_FETCH_PTR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
            end
            ST_FETCH_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + 32'd4;
            end
            ST_ISSUE: frag_valid = 1'b1;
            ST_WRITE_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_addr;
                mem_wdata[BIT_LAST]  = last_q;
                mem_wdata[LEN_W-1:0] = len_q;
            end
            ST_STEP: begin
                set_frag = irq_q;
                set_ring = (ci_nxt == produce);
            end
            default: ;
        endcase
    end

    assign consume   = ci_q;
    assign frag_addr = ptr_q;
    assign frag_len  = len_q;
    assign frag_last = last_q;

    // R11: request held stable until acknowledged
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R3: fragment request held stable until accepted
    a_r3_frag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr) && $stable(frag_len)));
    // R5: consume moves only two cycles after an accepted status write
    a_r5_step_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_q) |-> $past(mem_req && mem_we && mem_ack, 2));
    // R5: consume steps by one or wraps at ring last
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_q) |-> (ci_q == (($past(ci_q) == $past(ring_last)) ? '0 : $past(ci_q) + 1'b1)));
    // R6: an empty ring issues no request in the following cycle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ci_q == produce) |=> (!mem_req && !frag_valid));
endmodule

// File: rtl/txr_dma_top.sv
module txr_dma_top
    import txr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [2:0]         reg_wr_addr,
    input  logic [WORD_W-1:0]  reg_wr_data,
    input  logic [2:0]         reg_rd_addr,
    output logic [WORD_W-1:0]  reg_rd_data,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               frag_valid,
    output logic [WORD_W-1:0]  frag_addr,
    output logic [LEN_W-1:0]   frag_len,
    output logic               frag_last,
    input  logic               frag_ready,
    output logic               irq
);
    logic [WORD_W-1:0] desc_base, stat_base;
    logic [IDX_W-1:0]  ring_last, produce, consume;
    logic              set_frag, set_ring;

    txr_regs #(.IDX_W(IDX_W)) i_regs (
        .clk, .rst_n,
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .desc_base, .stat_base, .ring_last, .produce, .consume,
        .set_frag, .set_ring, .irq
    );

    txr_walker #(.IDX_W(IDX_W)) i_walker (
        .clk, .rst_n,
        .desc_base, .stat_base, .ring_last, .produce, .consume,
        .set_frag, .set_ring,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .frag_valid, .frag_addr, .frag_len, .frag_last, .frag_ready
    );
endmodule

// File: tb/test_txr_dma_top.sv
module test_txr_dma_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DBASE = 32'h7FE0_1100;
    localparam logic [31:0] SBASE = 32'h7FE0_1180;
    localparam int NV = 6;
    localparam logic [31:0] V_PTR [NV] = '{32'h0000_0200, 32'h0000_0208, 32'h0000_0240,
                                          32'h0000_02F0, 32'h0000_0214, 32'h0000_03C0};
    localparam logic [31:0] V_CTL [NV] = '{32'h8000_0007, 32'h4000_000B, 32'hC000_07FF,
                                          32'h0000_0000, 32'h8000_0010, 32'h4000_0400};

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [2:0] reg_wr_addr = '0, reg_rd_addr = '0;
    logic [31:0] reg_wr_data = '0, reg_rd_data;
    logic mem_req, mem_we, mem_ack, frag_valid, frag_last, frag_ready, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, frag_addr;
    logic [10:0] frag_len;
    logic mem_stall = 1'b0, frag_stall = 1'b0;

    logic [31:0] dmem [256];
    logic [31:0] smem [256];
    logic [31:0] prev_rd = '0, last_rd = '0, got_addr = '0;
    logic [10:0] got_len = '0;
    logic got_last = 1'b0;
    int frag_cnt = 0, req_cycles = 0;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_ack    = mem_req && !mem_stall;
    assign mem_rdata  = dmem[mem_addr[9:2]];
    assign frag_ready = frag_valid && !frag_stall;

    txr_dma_top i_txr_dma_top (
        .clk, .rst_n, .reg_wr_en, .reg_wr_addr, .reg_wr_data, .reg_rd_addr, .reg_rd_data,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .frag_valid, .frag_addr, .frag_len, .frag_last, .frag_ready, .irq
    );

    always @(negedge clk) begin
        if (mem_req || frag_valid) req_cycles <= req_cycles + 1;
        if (mem_req && mem_ack && mem_we) smem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && mem_ack && !mem_we) begin
            prev_rd <= last_rd;
            last_rd <= mem_addr;
        end
        if (frag_valid && frag_ready) begin
            frag_cnt <= frag_cnt + 1;
            got_addr <= frag_addr;
            got_len  <= frag_len;
            got_last <= frag_last;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic wait_ci(input logic [31:0] exp);
        logic [31:0] v;
        bit hit = 0;
        for (int k = 0; k < 400 && !hit; k++) begin
            @(negedge clk);
            reg_read(3'd4, v);
            if (v == exp) hit = 1;
        end
        check("R5 consume reached", v, exp);
    endtask

    task automatic put_desc(input int slot, input logic [31:0] p, input logic [31:0] c);
        logic [31:0] a;
        a = DBASE + 32'(slot * 8);
        dmem[a[9:2]]     = p;
        dmem[a[9:2] + 1] = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, sa, hold_addr;
        int fc0, rq0;
        for (int k = 0; k < 256; k++) begin dmem[k] = '0; smem[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int r = 0; r < 8; r++) begin
            reg_read(3'(r), v);
            check("R1 register reset", v, 32'h0);
        end
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        check("R1 no requests", {30'b0, mem_req, frag_valid}, 32'h0);

        reg_write(3'd0, DBASE | 32'h3);
        reg_read(3'd0, v);
        check("R2 base aligned", v, DBASE);
        reg_write(3'd1, SBASE);
        reg_write(3'd2, 32'd3);
        reg_write(3'd5, 32'd3);

        // table walk over the ring, wrapping once
        for (int i = 0; i < NV; i++) begin
            int slot;
            slot = i % 4;
            put_desc(slot, V_PTR[i], V_CTL[i]);
            reg_write(3'd3, 32'((i + 1) % 4));
            wait_ci(32'((i + 1) % 4));
            check("R2 pointer read address", prev_rd, DBASE + 32'(slot * 8));
            check("R2 control read address", last_rd, DBASE + 32'(slot * 8) + 32'd4);
            check("R3 fragment address", got_addr, V_PTR[i]);
            check("R3 fragment length", {21'b0, got_len}, {21'b0, V_CTL[i][10:0]});
            check("R3 fragment last", {31'b0, got_last}, {31'b0, V_CTL[i][30]});
            sa = SBASE + 32'(slot * 4);
            check("R4 status word", smem[sa[9:2]], V_CTL[i] & 32'h4000_07FF);
            reg_read(3'd6, v);
            check("R7 status bits", v, {30'b0, 1'b1, V_CTL[i][31]});
            check("R9 irq with mask on", {31'b0, irq}, 32'h1);
            reg_write(3'd7, 32'h3);
            reg_read(3'd6, v);
            check("R8 cleared", v, 32'h0);
        end

        // R6: empty ring stays quiet
        rq0 = req_cycles;
        repeat (20) @(negedge clk);
        check("R6 no requests when empty", 32'(req_cycles), 32'(rq0));

        // batch of three: ring-done only at the end (consume is 2)
        reg_write(3'd5, 32'h0);
        fc0 = frag_cnt;
        put_desc(2, 32'h100, 32'h8000_0003);
        put_desc(3, 32'h104, 32'h0000_0005);
        put_desc(0, 32'h108, 32'h4000_0009);
        reg_write(3'd3, 32'd1);
        wait_ci(32'd3);
        reg_read(3'd6, v);
        check("R7 no ring-done mid batch", v, 32'h1);
        wait_ci(32'd1);
        reg_read(3'd6, v);
        check("R7 ring-done at end", v, 32'h3);
        check("R3 batch fragment count", 32'(frag_cnt - fc0), 32'd3);
        check("R9 masked irq low", {31'b0, irq}, 32'h0);
        reg_write(3'd5, 32'h2);
        reg_read(3'd6, v);
        check("R9 status kept after enable", v, 32'h3);
        check("R9 irq via ring bit", {31'b0, irq}, 32'h1);
        reg_write(3'd5, 32'h0);
        reg_read(3'd6, v);
        check("R9 status kept after disable", v, 32'h3);
        check("R9 irq low again", {31'b0, irq}, 32'h0);

        // R8: clear lands on the same edge as the engine's set
        put_desc(1, 32'h120, 32'h0000_0002);
        reg_write(3'd3, 32'd2);
        do @(negedge clk); while (!(mem_req && mem_we && mem_ack));
        @(posedge clk);
        #1;
        reg_wr_en = 1'b1; reg_wr_addr = 3'd7; reg_wr_data = 32'h3;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
        @(negedge clk);
        reg_read(3'd6, v);
        check("R8 set wins over clear", v, 32'h2);
        reg_read(3'd4, v);
        check("R5 consume after collision", v, 32'd2);

        // R11 and R3: stalled handshakes hold their requests
        put_desc(2, 32'h500, 32'h8000_0001);
        mem_stall = 1'b1; frag_stall = 1'b1;
        reg_write(3'd3, 32'd3);
        do @(negedge clk); while (!mem_req);
        hold_addr = mem_addr;
        repeat (3) @(negedge clk);
        check("R11 request held", {31'b0, mem_req}, 32'h1);
        check("R11 address held", mem_addr, hold_addr);
        mem_stall = 1'b0;
        do @(negedge clk); while (!frag_valid);
        mem_stall = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 fragment held", {31'b0, frag_valid}, 32'h1);
        check("R3 fragment address held", frag_addr, 32'h500);
        frag_stall = 1'b0;
        mem_stall = 1'b0;
        wait_ci(32'd3);
        sa = SBASE + 32'd8;
        check("R4 status after stall", smem[sa[9:2]], 32'h0000_0001);

        // R10: read-only registers ignore writes
        reg_write(3'd4, 32'd1);
        reg_read(3'd4, v);
        check("R10 consume write ignored", v, 32'd3);
        reg_read(3'd6, v);
        sa = v;
        reg_write(3'd6, 32'h0);
        reg_read(3'd6, v);
        check("R10 status write ignored", v, sa);
        reg_read(3'd7, v);
        check("R10 clear reads zero", v, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule